// File: doc/BRIEF.md
# Two-Wire Controller Status Flag Engine

This block keeps the live status flags of a two-wire (I2C) controller. It takes single-cycle event strobes from the byte-level bus engine and single-cycle access strobes from the host register interface. From these it maintains a 16-bit read-only status word. Four flags are dynamic: transmit-complete, receive-ready, transmit-ready and not-acknowledged. Each one changes on the first rising clock edge after the strobe that moves it. Every other bit is a constant equal to its reset value. The status word is a combinational image of the flag registers, so the host sees the new value in the cycle after the edge.

Transmit-complete is driven by a small state machine with three named states. `TXC_DONE` means no frame is in progress and the flag reads one. `TXC_BUSY` means a frame is in progress and the flag reads zero. `TXC_RS_WAIT` means the bus is in slave mode, a repeated START has been seen, and the machine is waiting for the address byte. The transitions, in priority order, are:

- **set**: go to `TXC_DONE` when the set condition of the current mode holds.
- **rstart**: in slave mode, a repeated START outside `TXC_DONE` moves to `TXC_RS_WAIT`.
- **start**: a START moves to `TXC_BUSY`.
- **addr_hit**: in `TXC_RS_WAIT`, a matching address returns to `TXC_BUSY`.
- **hold**: otherwise the state does not change.

The other three flags are independent set/clear cells. In each cell a set strobe beats a clear strobe that arrives in the same cycle.

Top module: `twi_status_flags`

## Requirements
- R1: After reset the status word reads 0xF009.
- R2: The status word bit layout is fixed. Bit 0 is transmit-complete, bit 1 is receive-ready, bit 2 is transmit-ready and bit 8 is not-acknowledged. Bits 3, 12, 13, 14 and 15 always read one. Every other bit always reads zero.
- R3: In master mode, transmit-complete clears one cycle after a START strobe and stays low while the frame runs. It sets one cycle after a STOP strobe, but only if transmit-ready was one when the STOP arrived. A STOP that arrives while the holding register is full leaves it low.
- R4: In slave mode, transmit-complete clears one cycle after a START and sets one cycle after a STOP. After a repeated START inside a frame, it sets once the address phase ends with `addr_hit`=0. It stays low if the address matches.
- R5: Receive-ready sets one cycle after `ev_byte_in` and clears one cycle after `host_rd_rx`.
- R6: Transmit-ready clears one cycle after `host_wr_hold` and sets one cycle after `ev_load_shift`.
- R7: In master mode, `ev_nack` sets transmit-complete, transmit-ready and not-acknowledged on the same edge. In slave mode, `ev_nack` changes no flag.
- R8: `host_enable` sets transmit-ready on the next edge.
- R9: When a set strobe and a clear strobe for the same flag arrive in one cycle, the flag ends up set.
- R10: `host_rd_stat` clears not-acknowledged on the next edge. It leaves receive-ready and transmit-ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| ev_start | input | 1 | START detected or sent |
| ev_stop | input | 1 | STOP sent or detected |
| ev_rstart | input | 1 | Repeated START detected |
| ev_addr | input | 1 | Address phase complete |
| addr_hit | input | 1 | Address matched own slave address (valid with ev_addr) |
| ev_byte_in | input | 1 | Received byte loaded into receive holding register |
| ev_load_shift | input | 1 | Holding register moved into shifter |
| ev_nack | input | 1 | NACK detected |
| host_wr_hold | input | 1 | Host write of transmit holding register |
| host_rd_rx | input | 1 | Host read of receive holding register |
| host_rd_stat | input | 1 | Host read of status word |
| host_enable | input | 1 | Master enable strobe |
| status | output | 16 | Status word |

## Verification
The clocked assertions assume that `mode_master` is steady in the cycle of each strobe. They also assume that `addr_hit` is only meaningful while `ev_addr` is high. The START and address-hit checks exclude the cycles in which a STOP or an address miss coincides, because the set rule wins there. The stimulus changes mode only between frames, while all strobes are low. The random phases then hold the mode fixed for long runs and fire any mix of strobes, including collisions, which the reference model resolves by the same priority the requirements give.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;
    localparam int STAT_W     = 16;
    localparam int BIT_TXDONE = 0;
    localparam int BIT_RXFULL = 1;
    localparam int BIT_TXFREE = 2;
    localparam int BIT_NACK   = 8;
    // constant ones: bit 3 and bits 15:12
    localparam logic [STAT_W-1:0] STAT_FIXED = 16'hF008;

    typedef enum logic [1:0] {
        TXC_DONE    = 2'd0,
        TXC_BUSY    = 2'd1,
        TXC_RS_WAIT = 2'd2
    } txc_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rstart;
        logic addr;
        logic addr_hit;
        logic nack;
    } bus_ev_t;
endpackage

// File: rtl/twi_flag_cell.sv
module twi_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    logic q_nxt;

    always_comb begin
        q_nxt = q;
        if (set_i)
            q_nxt = 1'b1;
        else if (clr_i)
            q_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else
            q <= q_nxt;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q); // R9
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q); // R9
endmodule

// File: rtl/twi_txdone_fsm.sv
module twi_txdone_fsm
    import twi_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mode_master,
    input  bus_ev_t ev,
    input  logic    tx_empty,
    output logic    tx_done
);
    txc_state_t state, state_nxt;
    logic set_m, set_s, set_any;

    always_comb begin
        set_m   = ev.nack || (ev.stop && tx_empty);
        set_s   = ev.stop || ((state == TXC_RS_WAIT) && ev.addr && !ev.addr_hit);
        set_any = mode_master ? set_m : set_s;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TXC_DONE: begin
                if (set_any)
                    state_nxt = TXC_DONE;
                else if (ev.start)
                    state_nxt = TXC_BUSY;
            end
            TXC_BUSY: begin
                if (set_any)
                    state_nxt = TXC_DONE;
                else if (!mode_master && ev.rstart)
                    state_nxt = TXC_RS_WAIT;
            end
            TXC_RS_WAIT: begin
                if (set_any)
                    state_nxt = TXC_DONE;
                else if (!mode_master && ev.rstart)
                    state_nxt = TXC_RS_WAIT;
                else if (ev.start || ev.addr)
                    state_nxt = TXC_BUSY;
            end
            default: state_nxt = TXC_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= TXC_DONE;
        else
            state <= state_nxt;
    end

    always_comb begin
        tx_done = (state == TXC_DONE);
    end

    AST_M_NACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && ev.nack) |=> tx_done); // R7
    AST_M_STOP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && ev.stop && tx_empty) |=> tx_done); // R3
    AST_M_STOP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !tx_done && !ev.nack && !tx_empty) |=> !tx_done); // R3
    AST_S_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && ev.start && !ev.stop && !ev.addr) |=> !tx_done); // R4
    AST_S_STOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && ev.stop) |=> tx_done); // R4
endmodule

// File: rtl/twi_status_flags.sv
module twi_status_flags
    import twi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rstart,
    input  logic              ev_addr,
    input  logic              addr_hit,
    input  logic              ev_byte_in,
    input  logic              ev_load_shift,
    input  logic              ev_nack,
    input  logic              host_wr_hold,
    input  logic              host_rd_rx,
    input  logic              host_rd_stat,
    input  logic              host_enable,
    output logic [STAT_W-1:0] status
);
    bus_ev_t ev;
    logic    f_txdone, f_rxfull, f_txfree, f_nack;
    logic    nack_m;

    always_comb begin
        ev.start    = ev_start;
        ev.stop     = ev_stop;
        ev.rstart   = ev_rstart;
        ev.addr     = ev_addr;
        ev.addr_hit = addr_hit;
        ev.nack     = ev_nack;
        nack_m      = mode_master && ev_nack;
    end

    twi_txdone_fsm u_txdone (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_master (mode_master),
        .ev          (ev),
        .tx_empty    (f_txfree),
        .tx_done     (f_txdone)
    );

    twi_flag_cell #(.RST_VAL(1'b0)) u_rxfull (
        .clk (clk), .rst_n (rst_n),
        .set_i (ev_byte_in), .clr_i (host_rd_rx), .q (f_rxfull)
    );

    twi_flag_cell #(.RST_VAL(1'b0)) u_txfree (
        .clk (clk), .rst_n (rst_n),
        .set_i (ev_load_shift || host_enable || nack_m),
        .clr_i (host_wr_hold), .q (f_txfree)
    );

    twi_flag_cell #(.RST_VAL(1'b0)) u_nack (
        .clk (clk), .rst_n (rst_n),
        .set_i (nack_m), .clr_i (host_rd_stat), .q (f_nack)
    );

    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        if (i == BIT_TXDONE) begin : g_b
            assign status[i] = f_txdone;
        end else if (i == BIT_RXFULL) begin : g_b
            assign status[i] = f_rxfull;
        end else if (i == BIT_TXFREE) begin : g_b
            assign status[i] = f_txfree;
        end else if (i == BIT_NACK) begin : g_b
            assign status[i] = f_nack;
        end else begin : g_b
            assign status[i] = STAT_FIXED[i];
        end
    end

    AST_ENABLE_TXFREE: assert property (@(posedge clk) disable iff (!rst_n)
        host_enable |=> status[BIT_TXFREE]); // R8
    AST_NACK_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && ev_nack) |=> (status[BIT_NACK] && status[BIT_TXFREE] && status[BIT_TXDONE])); // R7
    AST_STATRD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stat && !nack_m) |=> !status[BIT_NACK]); // R10
    AST_STATRD_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stat && !ev_byte_in && !host_rd_rx) |=> (status[BIT_RXFULL] == $past(status[BIT_RXFULL]))); // R10
    AST_BYTE_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_in |=> status[BIT_RXFULL]); // R5
    AST_SLAVE_NO_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !status[BIT_NACK]) |=> !status[BIT_NACK]); // R7
endmodule

// File: tb/twi_status_flags_test.sv
module twi_status_flags_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_master = 1'b1;
    logic ev_start = 0, ev_stop = 0, ev_rstart = 0, ev_addr = 0, addr_hit = 0;
    logic ev_byte_in = 0, ev_load_shift = 0, ev_nack = 0;
    logic host_wr_hold = 0, host_rd_rx = 0, host_rd_stat = 0, host_enable = 0;
    logic [15:0] status;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // reference model state: phase 0 idle, 1 busy, 2 waiting for address
    int m_txc, m_rx, m_tx, m_nack, m_phase;

    always #2.5 clk = ~clk;

    twi_status_flags uut (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_rstart(ev_rstart),
        .ev_addr(ev_addr), .addr_hit(addr_hit), .ev_byte_in(ev_byte_in),
        .ev_load_shift(ev_load_shift), .ev_nack(ev_nack),
        .host_wr_hold(host_wr_hold), .host_rd_rx(host_rd_rx),
        .host_rd_stat(host_rd_stat), .host_enable(host_enable),
        .status(status)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txc = 1; m_rx = 0; m_tx = 0; m_nack = 0; m_phase = 0;
        end else begin
            int done_now, n_txc, n_phase;
            if (mode_master)
                done_now = (ev_nack || (ev_stop && m_tx == 1)) ? 1 : 0;
            else
                done_now = (ev_stop || (m_phase == 2 && ev_addr && !addr_hit)) ? 1 : 0;
            n_phase = m_phase;
            if (done_now == 1) n_phase = 0;
            else if (!mode_master && ev_rstart && m_phase != 0) n_phase = 2;
            else if (ev_start) n_phase = 1;
            else if (m_phase == 2 && ev_addr) n_phase = 1;
            n_txc = (n_phase == 0) ? 1 : 0;
            if (ev_byte_in) m_rx = 1; else if (host_rd_rx) m_rx = 0;
            if (ev_load_shift || host_enable || (mode_master && ev_nack)) m_tx = 1;
            else if (host_wr_hold) m_tx = 0;
            if (mode_master && ev_nack) m_nack = 1; else if (host_rd_stat) m_nack = 0;
            m_txc = n_txc; m_phase = n_phase;
        end
    end

    task automatic chk(string tag, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] exp_w;
        exp_w = 16'hF008;
        exp_w[0] = m_txc[0]; exp_w[1] = m_rx[0]; exp_w[2] = m_tx[0]; exp_w[8] = m_nack[0];
        chk("R3/R4 txcomp", status[0], m_txc);
        chk("R5 rxrdy", status[1], m_rx);
        chk("R6/R8 txrdy", status[2], m_tx);
        chk("R7/R10 nack", status[8], m_nack);
        chk("R2 word", status, exp_w);
    endtask

    task automatic clear_in();
        ev_start = 0; ev_stop = 0; ev_rstart = 0; ev_addr = 0; addr_hit = 0;
        ev_byte_in = 0; ev_load_shift = 0; ev_nack = 0;
        host_wr_hold = 0; host_rd_rx = 0; host_rd_stat = 0; host_enable = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        clear_in();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", status, 16'hF009);

        // master: enable, write frame ending in NACK
        mode_master = 1;
        host_enable = 1; tick();
        chk("R8 enable", status[2], 1);
        host_wr_hold = 1; tick();
        chk("R6 write clears", status[2], 0);
        ev_start = 1; tick();
        chk("R3 start clears", status[0], 0);
        ev_load_shift = 1; tick();
        chk("R6 load sets", status[2], 1);
        host_wr_hold = 1; tick();
        ev_stop = 1; tick();
        chk("R3 stop with full holding", status[0], 0);
        ev_nack = 1; tick();
        chk("R7 nack txcomp", status[0], 1);
        chk("R7 nack txrdy", status[2], 1);
        chk("R7 nack flag", status[8], 1);
        host_rd_stat = 1; tick();
        chk("R10 status read clears nack", status[8], 0);
        chk("R10 txrdy kept", status[2], 1);
        // clean master frame
        ev_start = 1; tick();
        ev_stop = 1; tick();
        chk("R3 stop with empty holding", status[0], 1);
        // collision write+load
        host_wr_hold = 1; ev_load_shift = 1; tick();
        chk("R9 txrdy set wins", status[2], 1);

        // slave receive frame
        mode_master = 0; tick();
        ev_start = 1; tick();
        chk("R4 slave start clears", status[0], 0);
        ev_byte_in = 1; tick();
        chk("R5 byte in", status[1], 1);
        host_rd_stat = 1; tick();
        chk("R10 rxrdy kept", status[1], 1);
        host_rd_rx = 1; tick();
        chk("R5 read clears", status[1], 0);
        ev_byte_in = 1; host_rd_rx = 1; tick();
        chk("R9 rxrdy set wins", status[1], 1);
        ev_nack = 1; tick();
        chk("R7 slave nack ignored", status[8], 0);
        ev_rstart = 1; tick();
        ev_addr = 1; addr_hit = 1; tick();
        chk("R4 address match stays busy", status[0], 0);
        ev_rstart = 1; tick();
        ev_addr = 1; addr_hit = 0; tick();
        chk("R4 address miss sets", status[0], 1);
        ev_start = 1; tick();
        ev_stop = 1; tick();
        chk("R4 slave stop sets", status[0], 1);

        // random phases, mode fixed per phase
        for (int seg = 0; seg < 8; seg++) begin
            mode_master = seg[0];
            tick();
            for (int c = 0; c < 400; c++) begin
                ev_start      = ($urandom % 10) == 0;
                ev_stop       = ($urandom % 12) == 0;
                ev_rstart     = ($urandom % 12) == 0;
                ev_addr       = ($urandom % 8) == 0;
                addr_hit      = $urandom % 2;
                ev_byte_in    = ($urandom % 6) == 0;
                ev_load_shift = ($urandom % 6) == 0;
                ev_nack       = ($urandom % 15) == 0;
                host_wr_hold  = ($urandom % 5) == 0;
                host_rd_rx    = ($urandom % 5) == 0;
                host_rd_stat  = ($urandom % 7) == 0;
                host_enable   = ($urandom % 20) == 0;
                tick();
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule